// File: doc/BRIEF.md
# Instruction Breakpoint and Vector Catch Unit

This unit watches the stream of retiring instructions and raises a debug event when an instruction address hits one of a small set of programmable breakpoints or one of the exception-vector catch addresses. Each instruction is described by its address, its size (16 or 32 bits) and whether it comes from the compact (mixed 16/32-bit) or the fixed-width (always 32-bit) instruction set. At most one event is reported per instruction.

Each breakpoint holds a word address, an enable, a match/mismatch mode, a 4-bit byte select and an optional link to another breakpoint. The link is the only context check: a linked breakpoint fires only when its target exists, is context-capable and is enabled. Vector-catch entries hold a halfword address and an enable. Software loads every entry through a simple one-cycle write port.

The result is registered. One cycle after the instruction strobe the unit presents a valid flag, a 2-bit type code and the index of the breakpoint that fired.

Top module: `bkpt_vcatch`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ev_valid` is 0, `ev_type` is 00 and `ev_idx` is 0.
- R2: For a fixed-width instruction (`icmp`=0), an enabled match-mode breakpoint fires when address bits [AW-1:2] equal its programmed word and the byte select is nonzero. This includes byte selects 1100 and 0011.
- R3: A byte select of 0000 makes the breakpoint behave as disabled in both match and mismatch mode.
- R4: For compact instructions, byte-select bits [1:0] cover the halfword at word+0 and bits [3:2] the halfword at word+2. A 32-bit compact instruction starting at the programmed word+2 with byte select 1111 counts as matching. In mismatch mode it therefore produces no event.
- R5: A 32-bit compact instruction whose second halfword alone hits a match-mode breakpoint raises the event on that instruction. The exception is the first 32-bit instruction after reset: for that one, the event is reported with the next valid instruction.
- R6: A mismatch-mode breakpoint raises an event for every instruction that does not match it.
- R7: A linked breakpoint fires only if its link index is below NUM_BP, the target is marked in CTX_MASK, and the target is enabled. Otherwise it raises no event.
- R8: A vector-catch entry hits an instruction at its exact address. For a 32-bit compact instruction it also hits at the address minus 2 and plus 2.
- R9: When both fire on the same instruction, a breakpoint takes priority over vector catch. Among breakpoints, the lowest index is reported on `ev_idx`.
- R10: `ev_type` codes are 00 none, 01 breakpoint and 10 vector catch. They are registered one cycle after `iv`. `ev_idx` is 0 unless the type is 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_vec | input | 1 | 1 selects the vector table, 0 the breakpoint table |
| cfg_idx | input | IW+1 | Entry index |
| cfg_addr | input | AW | Entry address |
| cfg_en | input | 1 | Entry enable |
| cfg_mis | input | 1 | Mismatch mode (breakpoints) |
| cfg_bas | input | 4 | Byte select (breakpoints) |
| cfg_lnk | input | 1 | Link enable (breakpoints) |
| cfg_lnk_idx | input | IW+1 | Link target index |
| iv | input | 1 | Instruction retire strobe |
| ia | input | AW | Instruction address |
| i32 | input | 1 | Instruction is 32 bits |
| icmp | input | 1 | Instruction is from the compact set |
| ev_valid | output | 1 | Debug event raised |
| ev_type | output | 2 | Event type code |
| ev_idx | output | IW | Index of the breakpoint that fired |

## Verification
The bench builds the unit with NUM_BP=4, NUM_VEC=2, AW=32 and CTX_MASK=1100. The link index is one bit wider than needed, so values 4 to 7 reach the nonexistent-target case. Only breakpoints 2 and 3 are context-capable, so a link to breakpoint 1 exercises the rejected-target case. The second vector entry shares its address with breakpoint 0, which puts the priority rule and the disabled-by-zero-byte-select rule on the same instruction. The deferral case is run as the very first 32-bit instruction after reset.

// File: rtl/bkpt_vcatch.sv
module bkpt_vcatch #(
  parameter int NUM_BP  = 4,
  parameter int NUM_VEC = 2,
  parameter int AW      = 32,
  parameter logic [NUM_BP-1:0] CTX_MASK = 4'b1100
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic                          cfg_vec,
  input  logic [$clog2(NUM_BP):0]       cfg_idx,
  input  logic [AW-1:0]                 cfg_addr,
  input  logic                          cfg_en,
  input  logic                          cfg_mis,
  input  logic [3:0]                    cfg_bas,
  input  logic                          cfg_lnk,
  input  logic [$clog2(NUM_BP):0]       cfg_lnk_idx,
  input  logic                          iv,
  input  logic [AW-1:0]                 ia,
  input  logic                          i32,
  input  logic                          icmp,
  output logic                          ev_valid,
  output logic [1:0]                    ev_type,
  output logic [$clog2(NUM_BP)-1:0]     ev_idx
);
  localparam int IW = $clog2(NUM_BP);
  localparam int LW = IW + 1;

  logic [AW-1:0] bp_a [NUM_BP];
  logic [3:0]    bp_bas [NUM_BP];
  logic [LW-1:0] bp_li [NUM_BP];
  logic [NUM_BP-1:0] bp_en, bp_mis, bp_lnk;
  logic [AW-1:0] vec_a [NUM_VEC];
  logic [NUM_VEC-1:0] vec_en;

  logic seen32, pend_v;
  logic [IW-1:0] pend_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_BP; k++) begin
        bp_a[k] <= '0; bp_bas[k] <= '0; bp_li[k] <= '0;
      end
      for (int k = 0; k < NUM_VEC; k++) vec_a[k] <= '0;
      bp_en <= '0; bp_mis <= '0; bp_lnk <= '0; vec_en <= '0;
    end else if (cfg_we) begin
      for (int k = 0; k < NUM_BP; k++)
        if (!cfg_vec && cfg_idx == LW'(k)) begin
          bp_a[k] <= cfg_addr; bp_bas[k] <= cfg_bas; bp_li[k] <= cfg_lnk_idx;
          bp_en[k] <= cfg_en; bp_mis[k] <= cfg_mis; bp_lnk[k] <= cfg_lnk;
        end
      for (int k = 0; k < NUM_VEC; k++)
        if (cfg_vec && cfg_idx == LW'(k)) begin
          vec_a[k] <= cfg_addr; vec_en[k] <= cfg_en;
        end
    end
  end

  wire [AW-1:0] ia2 = ia + AW'(2);
  wire wide_cmp = icmp & i32;
  wire [NUM_BP-1:0] ctx_ok = CTX_MASK & bp_en;

  logic [NUM_BP-1:0] fire, defer;
  logic [NUM_VEC-1:0] vhit;

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    wire w0 = ia[AW-1:2] == bp_a[i][AW-1:2];
    wire w1 = ia2[AW-1:2] == bp_a[i][AW-1:2];
    wire h0 = w0 & |(ia[1]  ? bp_bas[i][3:2] : bp_bas[i][1:0]);
    wire h1 = w1 & |(ia2[1] ? bp_bas[i][3:2] : bp_bas[i][1:0]);
    wire raw = icmp ? (h0 | (i32 & h1)) : (w0 & |bp_bas[i]);
    wire lok = !bp_lnk[i] ||
               (bp_li[i] < LW'(NUM_BP) && ctx_ok[bp_li[i][IW-1:0]]);
    wire cond = bp_en[i] & |bp_bas[i] & (bp_mis[i] ? ~raw : raw) & lok;
    wire late = wide_cmp & ~h0 & h1 & ~bp_mis[i] & ~seen32;
    assign fire[i]  = cond & ~late;
    assign defer[i] = cond & late;
  end

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    assign vhit[v] = vec_en[v] &
      ((ia == vec_a[v]) ||
       (wide_cmp && (ia == vec_a[v] - AW'(2) || ia == vec_a[v] + AW'(2))));
  end

  logic bp_any, df_any;
  logic [IW-1:0] bp_sel, df_sel;
  always_comb begin
    bp_any = 1'b0; bp_sel = '0; df_any = 1'b0; df_sel = '0;
    for (int k = NUM_BP - 1; k >= 0; k--) begin
      if (fire[k])  begin bp_any = 1'b1; bp_sel = IW'(k); end
      if (defer[k]) begin df_any = 1'b1; df_sel = IW'(k); end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_valid <= 1'b0; ev_type <= 2'b00; ev_idx <= '0;
      seen32 <= 1'b0; pend_v <= 1'b0; pend_idx <= '0;
    end else if (iv) begin
      if (i32) seen32 <= 1'b1;
      pend_v   <= df_any;
      pend_idx <= df_sel;
      if (pend_v) begin
        ev_valid <= 1'b1; ev_type <= 2'b01; ev_idx <= pend_idx;
      end else if (bp_any) begin
        ev_valid <= 1'b1; ev_type <= 2'b01; ev_idx <= bp_sel;
      end else if (|vhit) begin
        ev_valid <= 1'b1; ev_type <= 2'b10; ev_idx <= '0;
      end else begin
        ev_valid <= 1'b0; ev_type <= 2'b00; ev_idx <= '0;
      end
    end else begin
      ev_valid <= 1'b0; ev_type <= 2'b00; ev_idx <= '0;
    end
  end
endmodule

// File: rtl/bkpt_vcatch_chk.sv
module bkpt_vcatch_chk #(
  parameter int NUM_BP = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      iv,
  input logic                      ev_valid,
  input logic [1:0]                ev_type,
  input logic [$clog2(NUM_BP)-1:0] ev_idx
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !ev_valid && ev_type == 2'b00);

  // R10
  legal_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (ev_type == 2'b01 || ev_type == 2'b10));

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |-> (ev_type == 2'b00 && ev_idx == '0));

  // R10
  after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iv |=> !ev_valid);

  // R10
  vec_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_type == 2'b10 |-> ev_idx == '0);
endmodule

bind bkpt_vcatch bkpt_vcatch_chk #(.NUM_BP(NUM_BP)) chk_i (
  .clk(clk), .rst_n(rst_n), .iv(iv),
  .ev_valid(ev_valid), .ev_type(ev_type), .ev_idx(ev_idx)
);

// File: tb/bkpt_vcatch_tb_top.sv
`timescale 1ns/1ps
module bkpt_vcatch_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_vec = 0, cfg_en = 0, cfg_mis = 0, cfg_lnk = 0;
  logic [2:0] cfg_idx = '0, cfg_lnk_idx = '0;
  logic [31:0] cfg_addr = '0;
  logic [3:0] cfg_bas = '0;
  logic iv = 0, i32 = 0, icmp = 0;
  logic [31:0] ia = '0;
  logic ev_valid;
  logic [1:0] ev_type;
  logic [1:0] ev_idx;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  bkpt_vcatch #(.NUM_BP(4), .NUM_VEC(2), .AW(32), .CTX_MASK(4'b1100)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_vec(cfg_vec), .cfg_idx(cfg_idx),
    .cfg_addr(cfg_addr), .cfg_en(cfg_en), .cfg_mis(cfg_mis), .cfg_bas(cfg_bas),
    .cfg_lnk(cfg_lnk), .cfg_lnk_idx(cfg_lnk_idx), .iv(iv), .ia(ia), .i32(i32),
    .icmp(icmp), .ev_valid(ev_valid), .ev_type(ev_type), .ev_idx(ev_idx));

  // row: {icmp, i32, address, expected type, expected index}
  localparam logic [37:0] TAB [14] = '{
    {1'b0, 1'b1, 32'h1000, 2'b01, 2'd0},  // R9 bp beats vector
    {1'b0, 1'b1, 32'h2000, 2'b01, 2'd1},  // R2 bas 1100
    {1'b0, 1'b1, 32'h3000, 2'b01, 2'd2},  // R2 bas 0011
    {1'b0, 1'b1, 32'h1004, 2'b00, 2'd0},  // R2 other word
    {1'b1, 1'b0, 32'h1002, 2'b01, 2'd0},  // R4 upper halfword
    {1'b1, 1'b1, 32'h1002, 2'b01, 2'd0},  // R4 word+2, bas 1111
    {1'b1, 1'b0, 32'h2000, 2'b00, 2'd0},  // R4 lower halfword unselected
    {1'b1, 1'b0, 32'h2002, 2'b01, 2'd1},  // R4 upper halfword selected
    {1'b1, 1'b1, 32'h2FFE, 2'b01, 2'd2},  // R5 second halfword, immediate
    {1'b0, 1'b1, 32'h4000, 2'b10, 2'd0},  // R8 exact
    {1'b1, 1'b1, 32'h3FFE, 2'b10, 2'd0},  // R8 minus 2
    {1'b1, 1'b1, 32'h4002, 2'b10, 2'd0},  // R8 plus 2
    {1'b1, 1'b0, 32'h4002, 2'b00, 2'd0},  // R8 16-bit not widened
    {1'b1, 1'b0, 32'h1000, 2'b01, 2'd0}   // R9 compact overlap
  };

  task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wbp(int idx, logic [31:0] a, logic en, logic mis, logic [3:0] bas,
                     logic lnk, logic [2:0] li);
    @(negedge clk);
    cfg_we = 1; cfg_vec = 0; cfg_idx = 3'(idx); cfg_addr = a; cfg_en = en;
    cfg_mis = mis; cfg_bas = bas; cfg_lnk = lnk; cfg_lnk_idx = li;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wvec(int idx, logic [31:0] a);
    @(negedge clk);
    cfg_we = 1; cfg_vec = 1; cfg_idx = 3'(idx); cfg_addr = a; cfg_en = 1;
    @(negedge clk);
    cfg_we = 0; cfg_vec = 0;
  endtask

  task automatic run(string req, logic c, logic w, logic [31:0] a,
                     logic [1:0] et, logic [1:0] ei);
    @(negedge clk);
    iv = 1; icmp = c; i32 = w; ia = a;
    @(negedge clk);
    iv = 0;
    chk(req, {ev_valid, ev_type, ev_idx}, {et != 2'b00, et, ei});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 during reset", {ev_valid, ev_type, ev_idx}, 5'b0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", {ev_valid, ev_type, ev_idx}, 5'b0);

    wbp(0, 32'h1000, 1, 0, 4'b1111, 0, 0);
    wbp(1, 32'h2000, 1, 0, 4'b1100, 0, 0);
    wbp(2, 32'h3000, 1, 0, 4'b0011, 0, 0);
    wvec(0, 32'h4000);
    wvec(1, 32'h1000);

    run("R5 first 32-bit deferred", 1, 1, 32'h2FFE, 2'b00, 2'd0);
    run("R5 reported on next", 1, 0, 32'h5000, 2'b01, 2'd2);

    for (int r = 0; r < 14; r++)
      run($sformatf("table row %0d (R2/R4/R5/R8/R9)", r), TAB[r][37], TAB[r][36],
          TAB[r][35:4], TAB[r][3:2], TAB[r][1:0]);

    wbp(0, 32'h1000, 1, 0, 4'b0000, 0, 0);
    run("R3 zero bas match mode", 0, 1, 32'h1000, 2'b10, 2'd0);
    wbp(0, 32'h1000, 1, 1, 4'b0000, 0, 0);
    run("R3 zero bas mismatch mode", 0, 1, 32'h9000, 2'b00, 2'd0);

    wbp(3, 32'h8000, 1, 1, 4'b1111, 0, 0);
    run("R6 mismatch fires", 0, 1, 32'h9000, 2'b01, 2'd3);
    run("R6 mismatch quiet on match", 0, 1, 32'h8000, 2'b00, 2'd0);
    run("R4 mismatch word+2 counts as match", 1, 1, 32'h8002, 2'b00, 2'd0);

    wbp(3, 32'h2000, 1, 0, 4'b1111, 0, 0);
    run("R9 lowest index", 0, 1, 32'h2000, 2'b01, 2'd1);

    wbp(3, 32'h6000, 1, 0, 4'b1111, 1, 3'd2);
    run("R7 valid link", 0, 1, 32'h6000, 2'b01, 2'd3);
    wbp(3, 32'h6000, 1, 0, 4'b1111, 1, 3'd1);
    run("R7 link to non-context target", 0, 1, 32'h6000, 2'b00, 2'd0);
    wbp(3, 32'h6000, 1, 0, 4'b1111, 1, 3'd5);
    run("R7 link to missing target", 0, 1, 32'h6000, 2'b00, 2'd0);
    wbp(3, 32'h6000, 1, 0, 4'b1111, 1, 3'd2);
    wbp(2, 32'h3000, 0, 0, 4'b0011, 0, 0);
    run("R7 link to disabled target", 0, 1, 32'h6000, 2'b00, 2'd0);

    @(negedge clk);
    chk("R10 idle without strobe", {ev_valid, ev_type, ev_idx}, 5'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule